// File: doc/BRIEF.md
# Coalescing Store Buffer with Read Forwarding

This block sits between a write-through data cache and main memory. The processor hands it stores and gets an immediate accept, so it never waits for memory. Each buffered entry covers one whole cache line and records which bytes of that line have been written. A later store to a line that is already held is folded into the existing entry instead of using a new one. Entries leave for memory in the order they were opened, one line per memory transfer. Each transfer carries a byte mask that enables only the bytes that were actually written.

Loads are looked up in the cache and in this buffer at the same time. The block takes the word the cache returned and overlays any buffered bytes for that address, choosing the newest buffered copy of each byte. This keeps reads coherent with stores that have not yet reached memory. The buffer has four line entries. When all four are in use and a store matches none of them, the store is held off until the oldest entry has been written to memory.

Top module: `wbuf_coalesce`

## Requirements
- R1: After reset the buffer is empty: `memValid` is 0, `stReady` is 1, and `rdData` equals `rdCacheData`.
- R2: When a free entry exists, `stReady` is 1 whatever the state of `memReady`. A store presented with `stValid` while `stReady` is 1 is taken at that clock edge.
- R3: A store whose line matches a buffered entry that is not the oldest one is merged into that entry and opens no new entry. Such a merge is accepted even when all four entries are in use.
- R4: `rdData` is `rdCacheData` with each byte replaced by the newest buffered byte written to that address, if one exists. The replacement is combinational on `rdAddr` and reflects stores accepted at earlier clock edges.
- R5: `memValid` is 1 whenever the buffer holds an entry. `memAddr` is the oldest entry's line address with the offset bits zero. Entries leave oldest first, one per cycle in which `memValid` and `memReady` are both 1. While `memReady` is 0 the presented address, data and mask do not change.
- R6: When all four entries are valid and an incoming store matches no entry other than the oldest, `stReady` is 0. `stReady` returns to 1 in the cycle after the oldest entry is taken by memory.
- R7: A store to the same line as the oldest entry opens a new entry. The oldest entry's presented data and mask stay unchanged.
- R8: Byte `b` of word `w` in a line sits at `memData[(4*w+b)*8 +: 8]` with enable bit `memBe[4*w+b]`. The word within the line is address bits [3:2]. Only bytes written since the entry was opened have their enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stValid | input | 1 | Store request |
| stAddr | input | 32 | Store byte address |
| stData | input | 32 | Store data word |
| stBe | input | 4 | Store byte enables |
| stReady | output | 1 | Store accepted this cycle when high |
| rdAddr | input | 32 | Load byte address, looked up alongside the cache |
| rdCacheData | input | 32 | Word returned by the cache for `rdAddr` |
| rdData | output | 32 | Cache word with buffered bytes overlaid |
| memValid | output | 1 | Oldest entry offered to memory |
| memReady | input | 1 | Memory accepts the offered line |
| memAddr | output | 32 | Line byte address of the offered entry |
| memData | output | 128 | Line data of the offered entry |
| memBe | output | 16 | Byte enables of the offered entry |

## Verification
`stReady`, `memValid` and `rdData` are combinational functions of the current contents and the present inputs, so they are due in the same cycle as the stimulus. An accepted store shows up on `rdData` and on the memory outputs one cycle after the accepting edge. A drain handshake frees its entry, and raises `stReady` again, one cycle after its edge. The bench drives inputs just after the falling edge and samples all outputs 1 ns later, still before the rising edge. It then applies the accept and pop decisions to its own line model at the rising edge, so every comparison uses the state in force for that cycle.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;
  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic wrEn;   // a store is written into entry wrIdx
    logic wrNew;  // the written entry is freshly opened (clear old byte marks)
    logic pop;    // oldest entry handed to memory this cycle
  } wbCtrl_t;
endpackage

// File: rtl/wbuf_ctrl.sv
`timescale 1ns/1ps
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stValid,
  input  logic [ENTRIES-1:0] matchVec,
  input  logic               memReady,
  output logic               stReady,
  output logic               memValid,
  output wbCtrl_t            strb,
  output logic [IDX_W-1:0]   wrIdx,
  output logic [IDX_W-1:0]   headIdx,
  output logic [ENTRIES-1:0] validVec
);
  logic [IDX_W-1:0] headQ;
  logic [CNT_W-1:0] cntQ;
  logic [IDX_W-1:0] tailIdx;
  logic [IDX_W-1:0] candIdx;
  logic [ENTRIES-1:0] candVec;
  logic anyCand;
  logic isFull;
  logic push;

  // Entry i is live when its distance from the head is below the count.
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic [IDX_W-1:0] age;
      age = IDX_W'(i) - headQ;
      validVec[i] = CNT_W'(age) < cntQ;
      // The oldest entry may be on the memory bus, so it never takes a merge.
      candVec[i]  = validVec[i] && matchVec[i] && (IDX_W'(i) != headQ);
    end
  end

  always_comb begin
    anyCand = 1'b0;
    candIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (candVec[i] && !anyCand) begin
        anyCand = 1'b1;
        candIdx = IDX_W'(i);
      end
    end
  end

  assign isFull   = cntQ == CNT_W'(ENTRIES);
  assign tailIdx  = headQ + IDX_W'(cntQ);
  assign stReady  = anyCand || !isFull;
  assign memValid = cntQ != '0;

  assign strb.wrEn  = stValid && stReady;
  assign strb.wrNew = !anyCand;
  assign strb.pop   = memValid && memReady;
  assign push       = strb.wrEn && !anyCand;
  assign wrIdx      = anyCand ? candIdx : tailIdx;
  assign headIdx    = headQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ <= '0;
      cntQ  <= '0;
    end else begin
      if (strb.pop) headQ <= headQ + IDX_W'(1);
      cntQ <= cntQ + CNT_W'(push) - CNT_W'(strb.pop);
    end
  end
endmodule

// File: rtl/wbuf_dpath.sv
`timescale 1ns/1ps
module wbuf_dpath
  import wbuf_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  parameter int ENTRIES = 4,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int BYTES_W = WORD_W / 8,
  localparam int BSEL_W  = $clog2(BYTES_W),
  localparam int WSEL_W  = $clog2(WORDS),
  localparam int OFF_W   = BSEL_W + WSEL_W,
  localparam int LINE_AW = ADDR_W - OFF_W,
  localparam int LINE_W  = WORD_W * WORDS,
  localparam int LBE_W   = BYTES_W * WORDS
) (
  input  logic               clk,
  input  wbCtrl_t            strb,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [IDX_W-1:0]   headIdx,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ADDR_W-1:0]  stAddr,
  input  logic [WORD_W-1:0]  stData,
  input  logic [BYTES_W-1:0] stBe,
  output logic [ENTRIES-1:0] matchVec,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic [WORD_W-1:0]  rdCacheData,
  output logic [WORD_W-1:0]  rdData,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [LINE_W-1:0]  memData,
  output logic [LBE_W-1:0]   memBe
);
  logic [LINE_AW-1:0] lineQ [ENTRIES];
  logic [LINE_W-1:0]  dataQ [ENTRIES];
  logic [LBE_W-1:0]   beQ   [ENTRIES];

  logic [LINE_AW-1:0] stLine, rdLine;
  logic [WSEL_W-1:0]  stWord, rdWord;
  logic [2*BSEL_W-1:0] unusedByteSel;

  assign stLine = stAddr[ADDR_W-1:OFF_W];
  assign stWord = stAddr[OFF_W-1:BSEL_W];
  assign rdLine = rdAddr[ADDR_W-1:OFF_W];
  assign rdWord = rdAddr[OFF_W-1:BSEL_W];
  assign unusedByteSel = {stAddr[BSEL_W-1:0], rdAddr[BSEL_W-1:0]};

  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    logic [LINE_AW-1:0] lineR;
    logic [LINE_W-1:0]  dataR;
    logic [LBE_W-1:0]   beR;

    always_ff @(posedge clk) begin
      if (strb.wrEn && wrIdx == IDX_W'(e)) begin
        lineR <= stLine;
        for (int w = 0; w < WORDS; w++) begin
          for (int b = 0; b < BYTES_W; b++) begin
            if (WSEL_W'(w) == stWord && stBe[b]) begin
              dataR[(w*BYTES_W+b)*8 +: 8] <= stData[b*8 +: 8];
              beR[w*BYTES_W+b] <= 1'b1;
            end else if (strb.wrNew) begin
              beR[w*BYTES_W+b] <= 1'b0;
            end
          end
        end
      end
    end

    assign lineQ[e]    = lineR;
    assign dataQ[e]    = dataR;
    assign beQ[e]      = beR;
    assign matchVec[e] = lineR == stLine;
  end

  // Walk the entries from oldest to newest so younger bytes win.
  always_comb begin
    rdData = rdCacheData;
    for (int k = 0; k < ENTRIES; k++) begin
      logic [IDX_W-1:0] idx;
      idx = headIdx + IDX_W'(k);
      if (validVec[idx] && lineQ[idx] == rdLine) begin
        for (int b = 0; b < BYTES_W; b++) begin
          if (beQ[idx][int'(rdWord)*BYTES_W + b])
            rdData[b*8 +: 8] = dataQ[idx][(int'(rdWord)*BYTES_W + b)*8 +: 8];
        end
      end
    end
  end

  assign memAddr = {lineQ[headIdx], {OFF_W{1'b0}}};
  assign memData = dataQ[headIdx];
  assign memBe   = beQ[headIdx];
endmodule

// File: rtl/wbuf_coalesce.sv
`timescale 1ns/1ps
module wbuf_coalesce
  import wbuf_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  parameter int ENTRIES = 4   // power of two
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      stValid,
  input  logic [ADDR_W-1:0]         stAddr,
  input  logic [WORD_W-1:0]         stData,
  input  logic [WORD_W/8-1:0]       stBe,
  output logic                      stReady,
  input  logic [ADDR_W-1:0]         rdAddr,
  input  logic [WORD_W-1:0]         rdCacheData,
  output logic [WORD_W-1:0]         rdData,
  output logic                      memValid,
  input  logic                      memReady,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [WORDS*WORD_W-1:0]   memData,
  output logic [WORDS*WORD_W/8-1:0] memBe
);
  localparam int IDX_W = $clog2(ENTRIES);

  wbCtrl_t            strb;
  logic [IDX_W-1:0]   wrIdx, headIdx;
  logic [ENTRIES-1:0] validVec, matchVec;

  wbuf_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .matchVec(matchVec),
    .memReady(memReady), .stReady(stReady), .memValid(memValid),
    .strb(strb), .wrIdx(wrIdx), .headIdx(headIdx), .validVec(validVec)
  );

  wbuf_dpath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .ENTRIES(ENTRIES)) u_dpath (
    .clk(clk), .strb(strb), .wrIdx(wrIdx), .headIdx(headIdx), .validVec(validVec),
    .stAddr(stAddr), .stData(stData), .stBe(stBe), .matchVec(matchVec),
    .rdAddr(rdAddr), .rdCacheData(rdCacheData), .rdData(rdData),
    .memAddr(memAddr), .memData(memData), .memBe(memBe)
  );
endmodule

// File: rtl/wbuf_coalesce_chk.sv
`timescale 1ns/1ps
module wbuf_coalesce_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      stValid,
  input logic                      stReady,
  input logic [WORD_W-1:0]         rdCacheData,
  input logic [WORD_W-1:0]         rdData,
  input logic                      memValid,
  input logic                      memReady,
  input logic [ADDR_W-1:0]         memAddr,
  input logic [WORDS*WORD_W-1:0]   memData,
  input logic [WORDS*WORD_W/8-1:0] memBe
);
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && stReady) |=> memValid);

  assert_empty_fwd_R4: assert property (@(posedge clk) disable iff (!rstN)
    !memValid |-> (rdData == rdCacheData));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memData) && $stable(memBe)));

  assert_stall_R6: assert property (@(posedge clk) disable iff (!rstN)
    !stReady |-> memValid);

  assert_free_after_pop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady) |=> stReady);
endmodule

bind wbuf_coalesce wbuf_coalesce_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_chk (
  .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady),
  .rdCacheData(rdCacheData), .rdData(rdData), .memValid(memValid), .memReady(memReady),
  .memAddr(memAddr), .memData(memData), .memBe(memBe)
);

// File: tb/wbuf_coalesce_tb.sv
`timescale 1ns/1ps
module wbuf_coalesce_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         stValid = 1'b0;
  logic [31:0]  stAddr = '0;
  logic [31:0]  stData = '0;
  logic [3:0]   stBe = '0;
  logic         stReady;
  logic [31:0]  rdAddr = '0;
  logic [31:0]  rdCacheData = '0;
  logic [31:0]  rdData;
  logic         memValid;
  logic         memReady = 1'b0;
  logic [31:0]  memAddr;
  logic [127:0] memData;
  logic [15:0]  memBe;

  wbuf_coalesce u_dut (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stAddr(stAddr), .stData(stData),
    .stBe(stBe), .stReady(stReady), .rdAddr(rdAddr), .rdCacheData(rdCacheData),
    .rdData(rdData), .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memData(memData), .memBe(memBe)
  );

  always #2 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  int nTx = 0;

  // Bench line model: index 0 is the oldest entry.
  logic [27:0]  mLine [4];
  logic [127:0] mData [4];
  logic [15:0]  mBe   [4];
  int mCnt = 0;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] beMask(input logic [15:0] be);
    logic [127:0] m;
    for (int i = 0; i < 16; i++) m[i*8 +: 8] = be[i] ? 8'hFF : 8'h00;
    return m;
  endfunction

  // Drive one cycle at a falling edge, check, then update the model at the rising edge.
  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                      input logic rdy, input logic [31:0] ra, input logic [31:0] cd);
    int mergeIdx;
    bit expReady, accepted, popped;
    logic [31:0] fw;
    logic [127:0] mk;
    stValid = v; stAddr = a; stData = d; stBe = be;
    memReady = rdy; rdAddr = ra; rdCacheData = cd;
    #1;
    mergeIdx = -1;
    for (int j = 1; j < mCnt; j++) if (mLine[j] == a[31:4]) mergeIdx = j;
    expReady = (mergeIdx >= 0) || (mCnt < 4);
    check(stReady == expReady, (mCnt == 4 && mergeIdx < 0) ? "R6 stall" : "R2 accept",
          128'(stReady), 128'(expReady));
    check(memValid == (mCnt != 0), "R5 memValid", 128'(memValid), 128'(mCnt != 0));
    if (mCnt != 0) begin
      mk = beMask(mBe[0]);
      check(memAddr == {mLine[0], 4'b0}, "R5 memAddr", 128'(memAddr), 128'({mLine[0], 4'b0}));
      check(memBe == mBe[0], "R8 memBe", 128'(memBe), 128'(mBe[0]));
      check((memData & mk) == (mData[0] & mk), "R8 memData", memData & mk, mData[0] & mk);
    end
    fw = cd;
    for (int j = 0; j < mCnt; j++) begin
      if (mLine[j] == ra[31:4]) begin
        for (int b = 0; b < 4; b++)
          if (mBe[j][ra[3:2]*4 + b]) fw[b*8 +: 8] = mData[j][(ra[3:2]*4 + b)*8 +: 8];
      end
    end
    check(rdData == fw, "R4 forward", 128'(rdData), 128'(fw));
    accepted = v && expReady;
    popped = (mCnt != 0) && rdy;
    @(posedge clk);
    if (accepted) begin
      int t;
      if (mergeIdx >= 0) t = mergeIdx;
      else begin
        t = mCnt;
        mLine[t] = a[31:4];
        mBe[t] = '0;
        mData[t] = '0;
        mCnt++;
      end
      for (int b = 0; b < 4; b++) begin
        if (be[b]) begin
          mData[t][(a[3:2]*4 + b)*8 +: 8] = d[b*8 +: 8];
          mBe[t][a[3:2]*4 + b] = 1'b1;
        end
      end
    end
    if (popped) begin
      nTx++;
      for (int j = 0; j < 3; j++) begin
        mLine[j] = mLine[j+1]; mData[j] = mData[j+1]; mBe[j] = mBe[j+1];
      end
      mCnt--;
    end
    @(negedge clk);
  endtask

  localparam logic [31:0] LA = 32'h0000_1000;
  localparam logic [31:0] LB = 32'h0000_1010;
  localparam logic [31:0] LC = 32'h0000_1020;
  localparam logic [31:0] LD = 32'h0000_1030;

  initial begin
    #800000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    rdCacheData = 32'hCAFE_0001;
    rdAddr = LA;
    repeat (3) @(negedge clk);
    #1;
    check(memValid == 1'b0, "R1 memValid", 128'(memValid), 128'(0));
    check(stReady == 1'b1, "R1 stReady", 128'(stReady), 128'(1));
    check(rdData == 32'hCAFE_0001, "R1 rdData", 128'(rdData), 128'(32'hCAFE_0001));
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Directed: fill, oldest-line restore, merge, stall, drain.
    step(1, LA,      32'h1111_1111, 4'hF, 0, LA, 32'h0);
    step(1, LB,      32'hB0B0_B0B0, 4'h5, 0, LB, 32'hFFFF_FFFF);
    step(1, LA + 4,  32'h2222_2222, 4'h3, 0, LA, 32'h0);
    #1;
    check(memBe == 16'h000F, "R7 head mask", 128'(memBe), 128'(16'h000F));
    check(memData[31:0] == 32'h1111_1111, "R7 head data", 128'(memData[31:0]), 128'(32'h1111_1111));
    #1;
    step(1, LA + 8,  32'h3333_3333, 4'hF, 0, LA + 4, 32'h5555_5555);
    step(1, LC,      32'hC0C0_C0C0, 4'hF, 0, LA + 8, 32'h0);
    step(1, LD,      32'hD0D0_D0D0, 4'hF, 0, LB, 32'h1234_5678);
    step(1, LA + 12, 32'h4444_4444, 4'h9, 0, LA + 12, 32'h0);
    step(1, LD,      32'hD0D0_D0D0, 4'hF, 1, LA, 32'h0);
    step(1, LD,      32'hD0D0_D0D0, 4'hF, 0, LA, 32'h0);
    nTx = 0;
    for (int i = 0; i < 12 && mCnt != 0; i++) step(0, LA, 0, 4'h0, 1, LA + 4, 32'h7777_7777);
    check(nTx == 4, "R3 merged transfers", 128'(nTx), 128'(4));
    step(0, LA, 0, 4'h0, 1, LA + 8, 32'h8888_8888);

    // Sweep: every word and mask over three lines, slow drain.
    for (int w = 0; w < 4; w++) begin
      for (int m = 1; m < 16; m++) begin
        logic [31:0] a;
        a = LA + 32'((m % 3) * 16) + 32'(w * 4);
        step(1, a, 32'(m * 32'h0101_0101 + w), 4'(m), (m % 4) == 0, LA + 32'(m % 16 * 4), 32'hA5A5_5A5A);
      end
    end

    // Random traffic.
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a, ra;
      a  = LA + 32'(($urandom % 3) * 16) + 32'(($urandom % 4) * 4);
      ra = LA + 32'(($urandom % 3) * 16) + 32'(($urandom % 4) * 4);
      step(($urandom % 3) != 0, a, $urandom, 4'(1 + ($urandom % 15)),
           ($urandom % 4) == 0, ra, $urandom);
    end
    for (int i = 0; i < 12 && mCnt != 0; i++) step(0, LA, 0, 4'h0, 1, LA, 32'h0);
    step(0, LA, 0, 4'h0, 0, LA, 32'h0BAD_F00D);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule